// File: doc/BRIEF.md
# Early-Evaluating Elastic Two-Way Multiplexer

This block is a two-way multiplexer placed inside a synchronous elastic pipeline. Every channel uses a valid/stop handshake: a transfer happens in a cycle where valid is high and stop is low, and a sender that sees stop keeps its token unchanged until it is taken. There are three input channels: a one-bit select and two data inputs, called the left and right inputs. There is one output channel. For each select token, the output carries the left data when the select bit is 1 and the right data when it is 0.

The multiplexer does not wait for all inputs, as a plain join would. It fires once the select and the chosen data input are both valid and the output is not stopped. The input that was not chosen still owes one token for this firing. That debt is kept as a passive anti-token in a small saturating counter for that input. When the late token arrives, it is taken at once and cancelled against the counter, and no output is produced. If the unused input already holds a valid token when the block fires, that token is taken in the same cycle, and no anti-token is recorded.

Top module: `ee_mux`

## Requirements
- R1: On a firing, out_data equals lft_data when sel_bit is 1 and rgt_data when sel_bit is 0.
- R2: With sel_valid high, the chosen input valid, its anti-token count zero, and the unused input's count below ANTI_MAX, out_valid is high in that same cycle, whatever the unused input is doing.
- R3: A firing whose unused input is not valid adds one anti-token to that input. While an input's count is non-zero, its stop is low. Each token arriving there is consumed and decrements the count, and no output is produced.
- R4: A firing whose unused input is already valid, with a zero count, consumes that token in the same cycle (its stop is low) and leaves its count unchanged.
- R5: While out_stop is high, sel_stop stays high, and a data input with a zero count has its stop high.
- R6: An anti-token count never exceeds ANTI_MAX. When the unused input's count equals ANTI_MAX, out_valid is low and sel_stop is high.
- R7: out_valid is never high while sel_valid is low, so a late token cannot by itself produce an output.
- R8: Reset clears both counts, so after reset a valid data input with no select present sees stop high.
- R9: For any arrival order, the output token sequence equals, item by item, the chosen value of each select token against the data token with the same index on each input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_valid | input | 1 | Select token present |
| sel_bit | input | 1 | Select value: 1 picks the left input |
| sel_stop | output | 1 | Back-pressure to the select sender |
| lft_valid | input | 1 | Left data token present |
| lft_data | input | WIDTH | Left data |
| lft_stop | output | 1 | Back-pressure to the left sender |
| rgt_valid | input | 1 | Right data token present |
| rgt_data | input | WIDTH | Right data |
| rgt_stop | output | 1 | Back-pressure to the right sender |
| out_valid | output | 1 | Output token present |
| out_data | output | WIDTH | Output data |
| out_stop | input | 1 | Back-pressure from the receiver |

## Verification
The bench goes after several corner cases, each tied to a specific fault. It fires with the unused input absent: a design that waits for it would leave out_valid low. It sends the late token after the firing: a design that forgets the anti-token would block that token, or pair it with the next select and shift every later output by one. It fires while the unused input is already present: a design that records an anti-token anyway would later swallow a good token. It fills a counter to its maximum: a design that keeps firing would wrap the counter and lose the debt. A long random run then holds tokens back at random on every channel, applies random output back-pressure, and compares every output against the sequence built from the select and data streams.

// File: rtl/ee_mux.sv
module ee_mux #(
  parameter int WIDTH    = 8,
  parameter int ANTI_MAX = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_valid,
  input  logic             sel_bit,
  output logic             sel_stop,
  input  logic             lft_valid,
  input  logic [WIDTH-1:0] lft_data,
  output logic             lft_stop,
  input  logic             rgt_valid,
  input  logic [WIDTH-1:0] rgt_data,
  output logic             rgt_stop,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  input  logic             out_stop
);
  localparam int CW = $clog2(ANTI_MAX + 1);
  localparam logic [CW-1:0] CMAX = CW'(ANTI_MAX);

  logic [CW-1:0] lft_cnt, rgt_cnt;
  logic lft_kill, rgt_kill, lft_live, rgt_live;
  logic chosen_ok, blocked, fire;
  logic lft_inc, lft_dec, rgt_inc, rgt_dec;

  assign lft_kill  = lft_cnt != '0;
  assign rgt_kill  = rgt_cnt != '0;
  assign lft_live  = lft_valid && !lft_kill;
  assign rgt_live  = rgt_valid && !rgt_kill;
  assign chosen_ok = sel_bit ? lft_live : rgt_live;
  assign blocked   = sel_bit ? (rgt_cnt == CMAX) : (lft_cnt == CMAX);

  assign out_valid = sel_valid && chosen_ok && !blocked;
  assign out_data  = sel_bit ? lft_data : rgt_data;
  assign fire      = out_valid && !out_stop;

  assign sel_stop  = !fire;
  assign lft_stop  = !lft_kill && !fire;
  assign rgt_stop  = !rgt_kill && !fire;

  assign lft_inc = fire && !sel_bit && !lft_live;
  assign rgt_inc = fire &&  sel_bit && !rgt_live;
  assign lft_dec = lft_valid && lft_kill;
  assign rgt_dec = rgt_valid && rgt_kill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lft_cnt <= '0;
      rgt_cnt <= '0;
    end else begin
      case ({lft_inc, lft_dec})
        2'b10:   lft_cnt <= lft_cnt + 1'b1;
        2'b01:   lft_cnt <= lft_cnt - 1'b1;
        default: lft_cnt <= lft_cnt;
      endcase
      case ({rgt_inc, rgt_dec})
        2'b10:   rgt_cnt <= rgt_cnt + 1'b1;
        2'b01:   rgt_cnt <= rgt_cnt - 1'b1;
        default: rgt_cnt <= rgt_cnt;
      endcase
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (lft_cnt <= CMAX) && (rgt_cnt <= CMAX)); // R6
  AST_KILL_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ((lft_cnt != '0) |-> !lft_stop) and ((rgt_cnt != '0) |-> !rgt_stop)); // R3
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> sel_valid); // R7
  AST_SEL_WITH_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !sel_stop) |-> (out_valid && !out_stop)); // R5
  AST_DEBT_PAID: assert property (@(posedge clk) disable iff (!rst_n)
    (lft_valid && lft_cnt != '0 && !(fire && !sel_bit)) |=> lft_cnt == $past(lft_cnt) - 1'b1); // R3
endmodule

// File: tb/test_ee_mux.sv
module test_ee_mux;
  localparam int W = 8;
  localparam int AMAX = 3;
  localparam int N = 300;

  logic clk = 0, rst_n = 0;
  logic sv = 0, sb = 0, lv = 0, rv = 0, ost = 0;
  logic [W-1:0] ld = '0, rd = '0;
  logic sel_stop, lft_stop, rgt_stop, out_valid;
  logic [W-1:0] out_data;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  ee_mux #(.WIDTH(W), .ANTI_MAX(AMAX)) i_ee_mux (
    .clk(clk), .rst_n(rst_n),
    .sel_valid(sv), .sel_bit(sb), .sel_stop(sel_stop),
    .lft_valid(lv), .lft_data(ld), .lft_stop(lft_stop),
    .rgt_valid(rv), .rgt_data(rd), .rgt_stop(rgt_stop),
    .out_valid(out_valid), .out_data(out_data), .out_stop(ost));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pick(input logic s, input logic [W-1:0] a, input logic [W-1:0] b);
    return s ? a : b;
  endfunction

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  logic          sel_arr [N];
  logic [W-1:0]  l_arr   [N];
  logic [W-1:0]  r_arr   [N];

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int si, li, ri, oi, cyc;
    bit sa, la, ra, ox;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R8: no anti-tokens after reset
    lv = 1; ld = 8'h11; #1;
    chk(lft_stop == 1, "R8 lft_stop after reset", lft_stop, 1);
    chk(out_valid == 0, "R7 no output without select", out_valid, 0);
    lv = 0;
    step();

    // R1 R2: fire on left with right absent
    sv = 1; sb = 1; lv = 1; ld = 8'hA5; rv = 0; #1;
    chk(out_valid == 1, "R2 early fire", out_valid, 1);
    chk(out_data == 8'hA5, "R1 left chosen", out_data, 8'hA5);
    chk(sel_stop == 0 && lft_stop == 0, "R2 consumed", {sel_stop, lft_stop}, 0);
    step();
    sv = 0; lv = 0; rv = 1; rd = 8'h77; #1;
    chk(rgt_stop == 0, "R3 late token taken", rgt_stop, 0);
    chk(out_valid == 0, "R3 no output on late token", out_valid, 0);
    step();
    #1;
    chk(rgt_stop == 1, "R3 anti-token spent", rgt_stop, 1);
    rv = 0;
    step();

    // R4: unused already present
    sv = 1; sb = 0; lv = 1; ld = 8'h3C; rv = 1; rd = 8'hC3; #1;
    chk(out_data == 8'hC3 && out_valid, "R1 right chosen", out_data, 8'hC3);
    chk(lft_stop == 0, "R4 unused consumed", lft_stop, 0);
    step();
    sv = 0; rv = 0; ld = 8'h44; #1;
    chk(lft_stop == 1, "R4 no anti-token recorded", lft_stop, 1);
    lv = 0;
    step();

    // R5: output back-pressure
    sv = 1; sb = 1; lv = 1; ost = 1; #1;
    chk(sel_stop == 1 && lft_stop == 1, "R5 stalled", {sel_stop, lft_stop}, 3);
    chk(out_valid == 1, "R5 valid held", out_valid, 1);
    ost = 0;
    step();

    // R6: fill right counter
    for (int k = 0; k < AMAX - 1; k++) step();
    #1;
    chk(out_valid == 0 && sel_stop == 1, "R6 blocked at max", {out_valid, sel_stop}, 1);
    sv = 0; lv = 0;
    for (int k = 0; k < AMAX; k++) begin
      rv = 1; #1;
      chk(rgt_stop == 0 && out_valid == 0, "R6 drain", rgt_stop, 0);
      step();
    end
    #1;
    chk(rgt_stop == 1, "R6 drained to zero", rgt_stop, 1);
    rv = 0;
    step();

    // R9: random arrivals
    for (int i = 0; i < N; i++) begin
      sel_arr[i] = 1'($urandom);
      l_arr[i] = W'($urandom);
      r_arr[i] = W'($urandom);
    end
    si = 0; li = 0; ri = 0; oi = 0; cyc = 0;
    sv = 0; lv = 0; rv = 0;
    while ((oi < N || li < N || ri < N) && cyc < 20000) begin
      if (!sv && si < N && ($urandom % 3 != 0)) sv = 1;
      if (!lv && li < N && ($urandom % 2 == 0)) lv = 1;
      if (!rv && ri < N && ($urandom % 2 == 0)) rv = 1;
      if (si < N) sb = sel_arr[si];
      if (li < N) ld = l_arr[li];
      if (ri < N) rd = r_arr[ri];
      ost = ($urandom % 4 == 0);
      #4;
      sa = sv && !sel_stop;
      la = lv && !lft_stop;
      ra = rv && !rgt_stop;
      ox = out_valid && !ost;
      if (out_valid && !sv) chk(0, "R7 spurious output", 1, 0);
      if (ox) begin
        chk(oi < N && out_data == pick(sel_arr[oi], l_arr[oi], r_arr[oi]), "R9 output sequence",
            out_data, pick(sel_arr[oi], l_arr[oi], r_arr[oi]));
        oi++;
      end
      step();
      if (sa) begin si++; sv = 0; end
      if (la) begin li++; lv = 0; end
      if (ra) begin ri++; rv = 0; end
      cyc++;
    end
    chk(oi == N, "R9 all outputs", oi, N);
    chk(li == N && ri == N, "R3 all late tokens absorbed", li + ri, 2 * N);
    #1;
    lv = 1; rv = 1; sv = 0; #1;
    chk(lft_stop && rgt_stop, "R3 counters balanced", {lft_stop, rgt_stop}, 3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule